// File: doc/BRIEF.md
# External Memory Bus Cycle Controller

This block turns a single request from the processor core into one external memory cycle on a multiplexed address/data bus. The request carries an 18-bit address, a read/write flag, a code-fetch flag and a write byte. The block then runs the cycle. First it raises the address latch strobe. Next it drives one of the three active-low strobes: read, write or program-fetch. Last it returns the captured read byte together with a one-clock completion pulse.

The cycle shape comes from configuration inputs, which are sampled when the request is accepted:
- an active-low wait-state code that adds zero to three strobe periods;
- a short or long address latch pulse;
- page or non-page multiplexing, which decides which port carries the data.

Two inputs can stretch the strobe phase. An asynchronous wait input passes through a two-flop synchronizer. A synchronous wait input is honoured only while its enable is set. A free-running wait clock at half the clock rate can be switched on. One clock period stands for one oscillator period.

States and transitions of the controller:
- ST_IDLE goes to ST_ALE when a request arrives.
- ST_ALE stays for one or three clocks, then goes to ST_STRB.
- ST_STRB stays for one clock plus the wait states, plus any held clocks, then goes to ST_DONE.
- ST_DONE lasts one clock and returns to ST_IDLE.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: After reset, ale is 0, rd_n, wr_n and psen_n are 1, done is 0, both port enables are 0 and wclk is 0.
- R2: Every accepted request starts with ale high. Ale stays high for 3 clocks when cfg_ale_short is 0 and for 1 clock when it is 1. While ale is high, p0_out carries address bits 7:0, p2_out carries bits 15:8 and a_ext carries bits 17:16.
- R3: The strobe is low for 1 + W clocks. W is 3, 2, 1 or 0 for cfg_wait_n codes 00, 01, 10 or 11.
- R4: When address bits 17:16 equal 01, the strobe is low for exactly 1 clock, whatever the value of cfg_wait_n.
- R5: Exactly one strobe goes low in each cycle: wr_n for a write, psen_n for a read with req_code = 1, and rd_n for a read with req_code = 0.
- R6: Non-page mode (cfg_page = 0): p2_out keeps address bits 15:8 during the strobe. Port 0 carries the data during the strobe: p0_out with p0_oe = 1 for a write, and p0_oe = 0 for a read.
- R7: Page mode (cfg_page = 1): p0_out keeps address bits 7:0 during the strobe. Port 2 carries the data during the strobe: p2_out with p2_oe = 1 for a write, and p2_oe = 0 for a read.
- R8: The read byte is taken from the data port (p0_in in non-page mode, p2_in in page mode) on the last strobe clock. It appears on rdata when done is high. Done is high for exactly one clock, the clock right after the strobe returns high.
- R9: While await_n is low, after a two-flop synchronizer, the strobe phase is held. The cycle completes after await_n returns high.
- R10: A low level on wait_n holds the strobe phase only while cfg_sync_wait_en is 1. With the enable at 0, the strobe length is unchanged.
- R11: With cfg_wclk_en = 1, wclk toggles on every clock, which gives half the clock rate. With the enable at 0, wclk stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, taken while idle |
| req_addr | input | 18 | Cycle address |
| req_wr | input | 1 | 1 = write cycle |
| req_code | input | 1 | 1 = code fetch (program-fetch strobe on reads) |
| req_wdata | input | 8 | Write byte |
| cfg_wait_n | input | 2 | Active-low wait-state code |
| cfg_ale_short | input | 1 | 1 = one-clock latch pulse, 0 = three clocks |
| cfg_page | input | 1 | 1 = page mode, 0 = non-page mode |
| cfg_sync_wait_en | input | 1 | Enables the synchronous wait input |
| cfg_wclk_en | input | 1 | Enables the wait clock output |
| await_n | input | 1 | Asynchronous wait, low holds the cycle |
| wait_n | input | 1 | Synchronous wait, low holds the cycle when enabled |
| p0_in | input | 8 | Port 0 input value |
| p2_in | input | 8 | Port 2 input value |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Data read strobe |
| wr_n | output | 1 | Write strobe |
| psen_n | output | 1 | Program-fetch strobe |
| a_ext | output | 2 | Address bits 17:16 |
| p0_out | output | 8 | Port 0 drive value |
| p0_oe | output | 1 | Port 0 drive enable |
| p2_out | output | 8 | Port 2 drive value |
| p2_oe | output | 1 | Port 2 drive enable |
| rdata | output | 8 | Captured read byte |
| done | output | 1 | One-clock completion pulse |
| wclk | output | 1 | Wait clock |

## Verification
The bench builds the block with its default parameters: an 18-bit address and 8-bit data. With these values both address-extension bits exist, so region 01 can be exercised next to the other regions. The vector table pairs all four wait-state codes with both latch widths, both multiplexing modes and all three strobe kinds. Directed runs then hold each wait input low across a cycle and toggle the wait-clock enable.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ALE  = 2'd1,
        ST_STRB = 2'd2,
        ST_DONE = 2'd3
    } xbus_state_t;
endpackage

// File: rtl/xbus_sync.sv
module xbus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xbus_wclk.sv
module xbus_wclk (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic wclk
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  wclk <= 1'b0;
        else if (en) wclk <= ~wclk;
        else         wclk <= 1'b0;
    end

    AST_WCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> (wclk != $past(wclk))) // R11
        else $error("wclk did not toggle");
    AST_WCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en) |-> !wclk) // R11
        else $error("wclk not low while disabled");
endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    input  logic              req_code,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        cfg_wait_n,
    input  logic              cfg_ale_short,
    input  logic              cfg_page,
    input  logic              hold,
    input  logic [DATA_W-1:0] p0_in,
    input  logic [DATA_W-1:0] p2_in,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              psen_n,
    output logic [ADDR_W-2*DATA_W-1:0] a_ext,
    output logic [DATA_W-1:0] p0_out,
    output logic              p0_oe,
    output logic [DATA_W-1:0] p2_out,
    output logic              p2_oe,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);
    localparam int EXT_W = ADDR_W - 2*DATA_W;
    localparam logic [EXT_W-1:0] FAST_REGION = EXT_W'(1);

    xbus_state_t       state;
    logic [1:0]        cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wr_q, code_q, page_q;
    logic [1:0]        ws_q;
    logic [1:0]        ws_new;

    assign ws_new = (req_addr[ADDR_W-1:2*DATA_W] == FAST_REGION) ? 2'd0 : ~cfg_wait_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            code_q  <= 1'b0;
            page_q  <= 1'b0;
            ws_q    <= '0;
            rdata   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req) begin
                        state   <= ST_ALE;
                        cnt     <= cfg_ale_short ? 2'd0 : 2'd2;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        wr_q    <= req_wr;
                        code_q  <= req_code;
                        page_q  <= cfg_page;
                        ws_q    <= ws_new;
                    end
                end
                ST_ALE: begin
                    if (cnt == 2'd0) begin
                        state <= ST_STRB;
                        cnt   <= ws_q;
                    end else begin
                        cnt <= cnt - 2'd1;
                    end
                end
                ST_STRB: begin
                    if (!hold) begin
                        if (cnt == 2'd0) begin
                            state <= ST_DONE;
                            rdata <= page_q ? p2_in : p0_in;
                        end else begin
                            cnt <= cnt - 2'd1;
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ale    = 1'b0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        psen_n = 1'b1;
        a_ext  = '0;
        p0_out = '0;
        p0_oe  = 1'b0;
        p2_out = '0;
        p2_oe  = 1'b0;
        done   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ALE: begin
                ale    = 1'b1;
                a_ext  = addr_q[ADDR_W-1:2*DATA_W];
                p0_out = addr_q[DATA_W-1:0];
                p0_oe  = 1'b1;
                p2_out = addr_q[2*DATA_W-1:DATA_W];
                p2_oe  = 1'b1;
            end
            ST_STRB: begin
                wr_n   = ~wr_q;
                psen_n = ~(~wr_q & code_q);
                rd_n   = ~(~wr_q & ~code_q);
                a_ext  = addr_q[ADDR_W-1:2*DATA_W];
                if (page_q) begin
                    p0_out = addr_q[DATA_W-1:0];
                    p0_oe  = 1'b1;
                    p2_out = wr_q ? wdata_q : '0;
                    p2_oe  = wr_q;
                end else begin
                    p2_out = addr_q[2*DATA_W-1:DATA_W];
                    p2_oe  = 1'b1;
                    p0_out = wr_q ? wdata_q : '0;
                    p0_oe  = wr_q;
                end
            end
            ST_DONE: done = 1'b1;
        endcase
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~rd_n, ~wr_n, ~psen_n}) <= 1) // R5
        else $error("more than one strobe low");
    AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && psen_n)) // R2
        else $error("strobe during address latch");
    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(!rd_n || !wr_n || !psen_n)) // R8
        else $error("done without preceding strobe");
    AST_HOLD_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STRB && hold) |=> (state == ST_STRB)) // R9
        else $error("strobe ended while held");
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) // R8
        else $error("done longer than one clock");
endmodule

// File: rtl/xbus_cycle_ctrl.sv
module xbus_cycle_ctrl #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    input  logic              req_code,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        cfg_wait_n,
    input  logic              cfg_ale_short,
    input  logic              cfg_page,
    input  logic              cfg_sync_wait_en,
    input  logic              cfg_wclk_en,
    input  logic              await_n,
    input  logic              wait_n,
    input  logic [DATA_W-1:0] p0_in,
    input  logic [DATA_W-1:0] p2_in,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              psen_n,
    output logic [ADDR_W-2*DATA_W-1:0] a_ext,
    output logic [DATA_W-1:0] p0_out,
    output logic              p0_oe,
    output logic [DATA_W-1:0] p2_out,
    output logic              p2_oe,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              wclk
);
    logic await_s;
    logic hold;

    xbus_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(await_n), .q(await_s)
    );

    assign hold = ~await_s | (cfg_sync_wait_en & ~wait_n);

    xbus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .req_wr(req_wr), .req_code(req_code), .req_wdata(req_wdata),
        .cfg_wait_n(cfg_wait_n), .cfg_ale_short(cfg_ale_short),
        .cfg_page(cfg_page), .hold(hold), .p0_in(p0_in), .p2_in(p2_in),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .psen_n(psen_n),
        .a_ext(a_ext), .p0_out(p0_out), .p0_oe(p0_oe),
        .p2_out(p2_out), .p2_oe(p2_oe), .rdata(rdata), .done(done)
    );

    xbus_wclk u_wclk (
        .clk(clk), .rst_n(rst_n), .en(cfg_wclk_en), .wclk(wclk)
    );
endmodule

// File: tb/xbus_cycle_ctrl_test.sv
module xbus_cycle_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [17:0] req_addr = '0;
    logic        req_wr = 1'b0, req_code = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic [1:0]  cfg_wait_n = 2'b11;
    logic        cfg_ale_short = 1'b1, cfg_page = 1'b0;
    logic        cfg_sync_wait_en = 1'b0, cfg_wclk_en = 1'b0;
    logic        await_n = 1'b1, wait_n = 1'b1;
    logic [7:0]  p0_in = '0, p2_in = '0;
    logic        ale, rd_n, wr_n, psen_n, p0_oe, p2_oe, done, wclk;
    logic [1:0]  a_ext;
    logic [7:0]  p0_out, p2_out, rdata;

    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    xbus_cycle_ctrl uut (.*);

    // Fields: wr, code, addr, wdata, wait code, ale short, page, read byte
    localparam logic [39:0] VEC [8] = '{
        {1'b0, 1'b0, 18'h01234, 8'h00, 2'b11, 1'b1, 1'b0, 8'hA5},
        {1'b1, 1'b0, 18'h2ABCD, 8'h3C, 2'b00, 1'b0, 1'b0, 8'h00},
        {1'b0, 1'b1, 18'h3F00F, 8'h00, 2'b01, 1'b1, 1'b1, 8'h5A},
        {1'b1, 1'b0, 18'h0FFEE, 8'hC3, 2'b10, 1'b0, 1'b1, 8'h00},
        {1'b0, 1'b0, 18'h18001, 8'h00, 2'b00, 1'b1, 1'b0, 8'h96},
        {1'b1, 1'b0, 18'h17777, 8'h81, 2'b00, 1'b0, 1'b1, 8'h00},
        {1'b0, 1'b1, 18'h00000, 8'h00, 2'b00, 1'b0, 1'b0, 8'hFF},
        {1'b0, 1'b0, 18'h3FFFF, 8'h00, 2'b10, 1'b1, 1'b1, 8'h00}
    };

    int         t_ale, t_strb, t_done;
    logic       t_follow;
    logic [2:0] t_which;
    logic [7:0] t_lo, t_hi, t_d0, t_d2, t_rdata;
    logic [1:0] t_ext;
    logic       t_oe0, t_oe2;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input logic wr, input logic code, input logic [17:0] addr,
                           input logic [7:0] wd, input logic [1:0] ws, input logic ashort,
                           input logic page, input logic [7:0] rin);
        logic prev;
        logic [2:0] s;
        req_wr = wr; req_code = code; req_addr = addr; req_wdata = wd;
        cfg_wait_n = ws; cfg_ale_short = ashort; cfg_page = page;
        p0_in = page ? ~rin : rin;
        p2_in = page ? rin : ~rin;
        t_ale = 0; t_strb = 0; t_done = 0; t_follow = 0; t_which = '0;
        t_lo = '0; t_hi = '0; t_d0 = '0; t_d2 = '0; t_ext = '0; t_oe0 = 0; t_oe2 = 0;
        t_rdata = '0; prev = 0;
        req = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            req = 1'b0;
            if (ale) begin
                if (t_ale == 0) begin t_lo = p0_out; t_hi = p2_out; t_ext = a_ext; end
                t_ale++;
            end
            s = ~{psen_n, rd_n, wr_n};
            if (|s) begin
                if (t_strb == 0) begin t_d0 = p0_out; t_oe0 = p0_oe; t_d2 = p2_out; t_oe2 = p2_oe; end
                t_strb++;
                t_which = t_which | s;
            end
            if (done) begin t_done++; t_follow = prev; t_rdata = rdata; end
            prev = |s;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!ale && rd_n && wr_n && psen_n && !done && !p0_oe && !p2_oe && !wclk,
              "R1 idle outputs", {ale, rd_n, wr_n, psen_n, done, p0_oe, p2_oe, wclk}, 8'b01110000);

        foreach (VEC[k]) begin
            logic wr, code, ashort, page;
            logic [17:0] addr;
            logic [7:0] wd, rin;
            logic [1:0] ws;
            int exp_ale, exp_strb;
            logic [2:0] exp_which;
            {wr, code, addr, wd, ws, ashort, page, rin} = VEC[k];
            run_txn(wr, code, addr, wd, ws, ashort, page, rin);
            exp_ale = ashort ? 1 : 3;
            exp_strb = (addr[17:16] == 2'b01) ? 1 : 1 + (3 - int'(ws));
            exp_which = wr ? 3'b001 : (code ? 3'b100 : 3'b010);
            check(t_ale == exp_ale, "R2 ale width", t_ale, exp_ale);
            check(t_lo == addr[7:0] && t_hi == addr[15:8] && t_ext == addr[17:16],
                  "R2 address during ale", {t_ext, t_hi, t_lo}, addr);
            check(t_strb == exp_strb, (addr[17:16] == 2'b01) ? "R4 fast region width" : "R3 strobe width",
                  t_strb, exp_strb);
            check(t_which == exp_which, "R5 strobe select", t_which, exp_which);
            if (!page) begin
                check(t_d2 == addr[15:8] && t_oe2, "R6 port2 holds high address", t_d2, addr[15:8]);
                check(t_oe0 == wr && (!wr || t_d0 == wd), "R6 port0 data", {t_oe0, t_d0}, {wr, wr ? wd : t_d0});
            end else begin
                check(t_d0 == addr[7:0] && t_oe0, "R7 port0 holds low address", t_d0, addr[7:0]);
                check(t_oe2 == wr && (!wr || t_d2 == wd), "R7 port2 data", {t_oe2, t_d2}, {wr, wr ? wd : t_d2});
            end
            check(t_done == 1 && t_follow, "R8 done pulse", t_done, 1);
            if (!wr) check(t_rdata == rin, "R8 read data", t_rdata, rin);
        end

        // R9 asynchronous wait stretches the strobe
        await_n = 1'b0;
        fork
            run_txn(1'b0, 1'b0, 18'h00055, 8'h00, 2'b11, 1'b1, 1'b0, 8'h6B);
            begin repeat (10) @(negedge clk); await_n = 1'b1; end
        join
        check(t_strb >= 6 && t_done == 1, "R9 async wait hold", t_strb, 6);
        check(t_rdata == 8'h6B, "R9 read after hold", t_rdata, 8'h6B);

        // R10 synchronous wait ignored when disabled
        cfg_sync_wait_en = 1'b0; wait_n = 1'b0;
        run_txn(1'b0, 1'b0, 18'h00066, 8'h00, 2'b11, 1'b1, 1'b0, 8'h11);
        check(t_strb == 1 && t_done == 1, "R10 sync wait disabled", t_strb, 1);
        // R10 synchronous wait honoured when enabled
        cfg_sync_wait_en = 1'b1;
        fork
            run_txn(1'b1, 1'b0, 18'h00077, 8'h22, 2'b11, 1'b1, 1'b0, 8'h00);
            begin repeat (10) @(negedge clk); wait_n = 1'b1; end
        join
        check(t_strb >= 6 && t_done == 1, "R10 sync wait enabled", t_strb, 6);
        cfg_sync_wait_en = 1'b0;

        // R11 wait clock
        check(!wclk, "R11 wclk off", wclk, 0);
        cfg_wclk_en = 1'b1;
        @(negedge clk);
        begin
            logic w0;
            w0 = wclk;
            @(negedge clk);
            check(wclk != w0, "R11 wclk toggles", wclk, !w0);
            w0 = wclk;
            @(negedge clk);
            check(wclk != w0, "R11 wclk toggles again", wclk, !w0);
        end
        cfg_wclk_en = 1'b0;
        @(negedge clk); @(negedge clk);
        check(!wclk, "R11 wclk low after disable", wclk, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule